// File: doc/BRIEF.md
# Palette and Direct-Colour Pixel Expander

This block converts a stream of frame-memory words into a stream of 24-bit RGB pixels, one pixel per cycle at full rate. A 3-bit colour-depth code selects the format. The palette formats pack 2, 4 or 8 bits per index into one byte. Each index is looked up in a 256-entry table of 12-bit colours. The direct formats take one 16-bit word per pixel. Each output channel is eight bits wide. A narrower source value sits in the top bits of its channel and the bits below it are zero.

The palette table is loaded through its own write port, which never stalls the stream. A line-width input sets how many pixels make up a line. The pixel that closes a line is flagged. Any packed pixels left over in the final byte of a line are discarded, so the next line starts on a fresh byte. Both sides of the block use valid/ready handshakes. While the expander is still emitting pixels from the byte it holds, it keeps its input ready low.

Top module: `pixel_expander`

## Requirements
- R1: After a synchronous reset (rstN low at a clock edge), pixValid is 0. With a nonzero depth code, inReady is 1 in the first cycle after reset.
- R2: Depth code 0 is unsupported. While modeCode is 0, inReady stays 0 and no pixel is produced.
- R3: With depth code 1 (2 bits per pixel), each accepted byte inData[7:0] yields four pixels in this order: bits 1:0, then 3:2, then 5:4, then 7:6. Each value is used as a palette index.
- R4: With depth code 2 (4 bits per pixel), each accepted byte yields two pixels. The low nibble comes first, then the high nibble, each used as a palette index.
- R5: With depth code 3 (8 bits per pixel), each accepted byte inData[7:0] is one palette index and yields one pixel.
- R6: A 12-bit palette colour c is expanded as follows: pixData[23:16] = {c[11:8],4'h0}, pixData[15:8] = {c[7:4],4'h0}, pixData[7:0] = {c[3:0],4'h0}.
- R7: With depth codes 4 to 7 and tftMode at 0, each inData word gives one pixel. Bits 11:0 are expanded as in R6, and bits 15:12 have no effect.
- R8: With depth codes 4 to 7 and tftMode at 1, each word is 5:6:5. Red is bits 15:11, green is bits 10:5 and blue is bits 4:0, each placed at the top of its 8-bit channel with zero fill below.
- R9: The pixel numbered lineWidth in a line (counting from 1) carries pixLast at 1, and every other pixel carries it at 0. Packed pixels left in that pixel's byte are dropped, and the next accepted byte begins a new line.
- R10: While pixValid is 1 and pixReady is 0, the next cycle keeps pixValid, pixData and pixLast unchanged, and no pixel is lost.
- R11: A palette write (palWrEn at a clock edge) affects every pixel emitted at a later edge that uses that index.
- R12: Once a word has been accepted, a pixel is valid two edges later. With pixReady held at 1 and input always offered in 8-bit or 16-bit modes, pixels are emitted on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| modeCode | input | 3 | Colour-depth code (0 unsupported, 1/2/3 palette 2/4/8 bpp, 4-7 direct 16 bpp) |
| tftMode | input | 1 | In 16 bpp modes selects 5:6:5 (1) or 4:4:4 (0) |
| lineWidth | input | LINE_CNT_W | Pixels per line, at least 1 |
| inData | input | 16 | Input word; palette modes use bits 7:0 |
| inValid | input | 1 | Input word offered |
| inReady | output | 1 | Input word taken at this edge when inValid is 1 |
| palWrEn | input | 1 | Palette write strobe |
| palWrAddr | input | 8 | Palette entry to write |
| palWrData | input | 12 | Palette colour, 4:4:4 |
| pixData | output | 24 | Pixel, red in 23:16, green in 15:8, blue in 7:0 |
| pixValid | output | 1 | Pixel present |
| pixReady | input | 1 | Pixel taken at this edge when pixValid is 1 |
| pixLast | output | 1 | Pixel closes the line |

## Verification
An accepted word sits in a holding register for one edge. Its first pixel is registered at the next edge, so it is valid two edges after acceptance. Later packed pixels follow one per edge in which the output can advance. The bench drives inputs on the falling edge and samples handshakes and outputs 3 ns later, just before the rising edge. It compares each transferred pixel with an expected queue built arithmetically from the requirements, so the result does not depend on exact latency under random backpressure. Back-to-back timing is checked separately by measuring the gap between consecutive transfers in an unstalled 8-bit sweep.

// File: rtl/pxe_pkg.sv
`timescale 1ns/1ps
package pxe_pkg;
  localparam int WORD_W = 16;
  localparam int IDX_W  = 8;
  localparam int COL_W  = 12;
  localparam int CH_W   = 8;
  localparam int PIX_W  = 3 * CH_W;

  typedef enum logic [2:0] {
    DEP_NONE = 3'd0,
    DEP_2    = 3'd1,
    DEP_4    = 3'd2,
    DEP_8    = 3'd3,
    DEP_16   = 3'd4
  } depth_e;

  typedef struct packed {
    logic       loadWord;
    logic       emitPix;
    logic [1:0] subSel;
  } pxeStrobes_t;

  function automatic depth_e decodeDepth(input logic [2:0] code);
    case (code)
      3'd0:    return DEP_NONE;
      3'd1:    return DEP_2;
      3'd2:    return DEP_4;
      3'd3:    return DEP_8;
      default: return DEP_16;
    endcase
  endfunction

  function automatic logic [1:0] lastSubOf(input depth_e d);
    case (d)
      DEP_2:   return 2'd3;
      DEP_4:   return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [PIX_W-1:0] expand444(input logic [COL_W-1:0] c);
    return {c[11:8], 4'h0, c[7:4], 4'h0, c[3:0], 4'h0};
  endfunction

  function automatic logic [PIX_W-1:0] expand565(input logic [WORD_W-1:0] w);
    return {w[15:11], 3'b000, w[10:5], 2'b00, w[4:0], 3'b000};
  endfunction
endpackage

// File: rtl/pxe_palette.sv
`timescale 1ns/1ps
module pxe_palette #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrAddr] <= wrData;
  end

  // Read is combinational; a write lands at the edge, so a same-edge read sees the old entry.
  assign rdData = mem[rdAddr];
endmodule

// File: rtl/pxe_ctrl.sv
`timescale 1ns/1ps
module pxe_ctrl
  import pxe_pkg::*;
#(
  parameter int LINE_CNT_W = 10
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [2:0]            modeCode,
  input  logic [LINE_CNT_W-1:0] lineWidth,
  input  logic                  inValid,
  output logic                  inReady,
  input  logic                  pixReady,
  output logic                  pixValid,
  output logic                  pixLast,
  output pxeStrobes_t           strobes
);
  localparam int CNT_EXT_W = LINE_CNT_W + 1;

  depth_e                depth;
  logic [1:0]            lastSub;
  logic                  haveWord;
  logic [1:0]            subIdx;
  logic [LINE_CNT_W-1:0] pixCnt;
  logic                  outAdv;
  logic                  emit;
  logic                  lineEnd;
  logic                  wordDone;
  logic                  accept;

  assign depth   = decodeDepth(modeCode);
  assign lastSub = lastSubOf(depth);

  // Output register may take a new pixel when empty or being drained.
  assign outAdv  = !pixValid || pixReady;
  assign emit    = haveWord && outAdv;
  assign lineEnd = ({1'b0, pixCnt} + CNT_EXT_W'(1)) == {1'b0, lineWidth};

  // The held word is finished on its last sub-pixel or at the end of the line.
  assign wordDone = emit && ((subIdx == lastSub) || lineEnd);
  assign inReady  = (depth != DEP_NONE) && (!haveWord || wordDone);
  assign accept   = inValid && inReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      haveWord <= 1'b0;
      subIdx   <= '0;
      pixCnt   <= '0;
      pixValid <= 1'b0;
      pixLast  <= 1'b0;
    end else begin
      if (accept)        haveWord <= 1'b1;
      else if (wordDone) haveWord <= 1'b0;

      if (accept || wordDone) subIdx <= '0;
      else if (emit)          subIdx <= subIdx + 2'd1;

      if (emit) pixCnt <= lineEnd ? '0 : pixCnt + LINE_CNT_W'(1);

      if (emit) begin
        pixValid <= 1'b1;
        pixLast  <= lineEnd;
      end else if (pixReady) begin
        pixValid <= 1'b0;
      end
    end
  end

  assign strobes = '{loadWord: accept, emitPix: emit, subSel: subIdx};
endmodule

// File: rtl/pxe_datapath.sv
`timescale 1ns/1ps
module pxe_datapath
  import pxe_pkg::*;
(
  input  logic              clk,
  input  logic [2:0]        modeCode,
  input  logic              tftMode,
  input  logic [WORD_W-1:0] inData,
  input  pxeStrobes_t       strobes,
  output logic [IDX_W-1:0]  palRdAddr,
  input  logic [COL_W-1:0]  palRdData,
  output logic [PIX_W-1:0]  pixData
);
  localparam int N_SUB2 = IDX_W / 2;
  localparam int N_SUB4 = IDX_W / 4;

  depth_e            depth;
  logic [WORD_W-1:0] wordQ;
  logic [1:0]        idx2 [N_SUB2];
  logic [3:0]        idx4 [N_SUB4];
  logic [PIX_W-1:0]  nextPix;

  assign depth = decodeDepth(modeCode);

  // Packed fields of the held byte, lowest field at slot 0.
  for (genvar g = 0; g < N_SUB2; g++) begin : gSlice2
    assign idx2[g] = wordQ[2*g +: 2];
  end
  for (genvar g = 0; g < N_SUB4; g++) begin : gSlice4
    assign idx4[g] = wordQ[4*g +: 4];
  end

  always_comb begin
    case (depth)
      DEP_2:   palRdAddr = IDX_W'(idx2[strobes.subSel]);
      DEP_4:   palRdAddr = IDX_W'(idx4[strobes.subSel[0]]);
      default: palRdAddr = wordQ[IDX_W-1:0];
    endcase
  end

  always_comb begin
    if (depth == DEP_16) begin
      nextPix = tftMode ? expand565(wordQ) : expand444(wordQ[COL_W-1:0]);
    end else begin
      nextPix = expand444(palRdData);
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.loadWord) wordQ   <= inData;
    if (strobes.emitPix)  pixData <= nextPix;
  end
endmodule

// File: rtl/pixel_expander.sv
`timescale 1ns/1ps
module pixel_expander
  import pxe_pkg::*;
#(
  parameter int LINE_CNT_W = 10
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [2:0]            modeCode,
  input  logic                  tftMode,
  input  logic [LINE_CNT_W-1:0] lineWidth,
  input  logic [15:0]           inData,
  input  logic                  inValid,
  output logic                  inReady,
  input  logic                  palWrEn,
  input  logic [7:0]            palWrAddr,
  input  logic [11:0]           palWrData,
  output logic [23:0]           pixData,
  output logic                  pixValid,
  input  logic                  pixReady,
  output logic                  pixLast
);
  pxeStrobes_t      strobes;
  logic [IDX_W-1:0] palRdAddr;
  logic [COL_W-1:0] palRdData;

  pxe_ctrl #(.LINE_CNT_W(LINE_CNT_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .modeCode (modeCode),
    .lineWidth(lineWidth),
    .inValid  (inValid),
    .inReady  (inReady),
    .pixReady (pixReady),
    .pixValid (pixValid),
    .pixLast  (pixLast),
    .strobes  (strobes)
  );

  pxe_datapath u_dp (
    .clk      (clk),
    .modeCode (modeCode),
    .tftMode  (tftMode),
    .inData   (inData),
    .strobes  (strobes),
    .palRdAddr(palRdAddr),
    .palRdData(palRdData),
    .pixData  (pixData)
  );

  pxe_palette #(.ADDR_W(IDX_W), .DATA_W(COL_W)) u_pal (
    .clk   (clk),
    .wrEn  (palWrEn),
    .wrAddr(palWrAddr),
    .wrData(palWrData),
    .rdAddr(palRdAddr),
    .rdData(palRdData)
  );
endmodule

// File: rtl/pxe_checker.sv
`timescale 1ns/1ps
module pxe_checker (
  input logic        clk,
  input logic        rstN,
  input logic [2:0]  modeCode,
  input logic        inValid,
  input logic        inReady,
  input logic [23:0] pixData,
  input logic        pixValid,
  input logic        pixReady,
  input logic        pixLast
);
  assert_reset_idle_R1: assert property (@(posedge clk) !rstN |=> !pixValid);

  assert_mode0_blocked_R2: assert property (@(posedge clk) disable iff (!rstN)
    (modeCode == 3'd0) |-> !inReady);

  assert_pad_bits_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |-> (pixData[18:16] == 3'd0 && pixData[9:8] == 2'd0 && pixData[2:0] == 3'd0));

  assert_hold_stalled_R10: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && !pixReady) |=> (pixValid && $stable(pixData) && $stable(pixLast)));

  assert_accept_latency_R12: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |-> ##2 pixValid);
endmodule

bind pixel_expander pxe_checker u_chk (.*);

// File: tb/sim_pixel_expander.sv
`timescale 1ns/1ps
module sim_pixel_expander;
  localparam int LW = 10;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [2:0]    modeCode = 3'd3;
  logic          tftMode = 1'b0;
  logic [LW-1:0] lineWidth = 10'd1;
  logic [15:0]   inData = '0;
  logic          inValid = 1'b0;
  logic          inReady;
  logic          palWrEn = 1'b0;
  logic [7:0]    palWrAddr = '0;
  logic [11:0]   palWrData = '0;
  logic [23:0]   pixData;
  logic          pixValid;
  logic          pixReady = 1'b1;
  logic          pixLast;

  pixel_expander #(.LINE_CNT_W(LW)) u0 (.*);

  always #4 clk = ~clk;

  int          nChecks = 0;
  int          nFails  = 0;
  bit          finished = 0;
  int          cyc = 0;
  string       curReq = "R1";
  logic [11:0] palModel [256];
  logic [24:0] expQ [$];
  int          gotCnt = 0;
  int          pushCnt = 0;
  bit          stallOn = 0;
  bit          gapCheck = 0;
  bit          havePrev = 0;
  int          prevCyc = 0;
  logic [7:0]  lfsr = 8'hA5;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  function automatic logic [23:0] chan444(input logic [11:0] c);
    int r, g, b;
    r = ((int'(c) >> 8) & 15) * 16;
    g = ((int'(c) >> 4) & 15) * 16;
    b = (int'(c) & 15) * 16;
    return {8'(r), 8'(g), 8'(b)};
  endfunction

  function automatic logic [23:0] refPix(input int mode, input bit tft, input logic [15:0] w, input int sub);
    int v, r, g, b, idx;
    v = int'(w);
    if (mode >= 4) begin
      if (tft) begin
        r = ((v >> 11) & 31) * 8;
        g = ((v >> 5) & 63) * 4;
        b = (v & 31) * 8;
        return {8'(r), 8'(g), 8'(b)};
      end
      return chan444(12'(v % 4096));
    end
    if (mode == 1)      idx = (v >> (2 * sub)) % 4;
    else if (mode == 2) idx = (v >> (4 * sub)) % 16;
    else                idx = v % 256;
    return chan444(palModel[idx]);
  endfunction

  function automatic logic [15:0] genWord(input int seed, input int k);
    if (seed == 0) return 16'(k);
    if (seed == 1) return 16'h0055;
    return 16'((k * 40503 + seed * 977) ^ (k * 131 + 7));
  endfunction

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  // Output backpressure pattern
  initial forever begin
    @(negedge clk);
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    pixReady = stallOn ? (lfsr[0] | lfsr[2]) : 1'b1;
  end

  // Output monitor, samples just before the rising edge
  initial forever begin
    @(negedge clk);
    #3;
    if (rstN && pixValid && pixReady) begin
      logic [24:0] e;
      gotCnt++;
      if (expQ.size() == 0) begin
        check(1'b0, curReq, {7'd0, pixLast, pixData}, 32'hDEAD);
      end else begin
        e = expQ.pop_front();
        check({pixLast, pixData} == e, curReq, {7'd0, pixLast, pixData}, {7'd0, e});
      end
      if (gapCheck) begin
        if (havePrev) check(cyc - prevCyc == 1, "R12", 32'(cyc - prevCyc), 32'd1);
        havePrev = 1;
      end
      prevCyc = cyc;
    end
  end

  task automatic palWrite(input int a, input logic [11:0] d);
    @(negedge clk);
    palWrEn = 1'b1;
    palWrAddr = 8'(a);
    palWrData = d;
    palModel[a] = d;
    @(negedge clk);
    palWrEn = 1'b0;
  endtask

  task automatic sendWord(input logic [15:0] d);
    bit acc;
    acc = 0;
    while (!acc) begin
      @(negedge clk);
      inValid = 1'b1;
      inData = d;
      #3;
      if (inReady) acc = 1;
    end
  endtask

  task automatic sendLine(input int mode, input bit tft, input int w, input int seed);
    int ppw, pc, k;
    logic [15:0] d;
    ppw = (mode == 1) ? 4 : (mode == 2) ? 2 : 1;
    pc = 0;
    k = 0;
    while (pc < w) begin
      d = genWord(seed, k);
      for (int s = 0; s < ppw; s++) begin
        if (pc < w) begin
          expQ.push_back({pc == w - 1, refPix(mode, tft, d, s)});
          pushCnt++;
          pc++;
        end
      end
      sendWord(d);
      k++;
    end
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic setup(input int mode, input bit tft, input int w, input string req);
    @(negedge clk);
    modeCode = 3'(mode);
    tftMode = tft;
    lineWidth = LW'(w);
    curReq = req;
  endtask

  task automatic drain();
    int t;
    t = 0;
    while (expQ.size() != 0 && t < 5000) begin
      @(negedge clk);
      t++;
    end
    repeat (4) @(negedge clk);
    check(gotCnt == pushCnt, curReq, 32'(gotCnt), 32'(pushCnt));
    gotCnt = 0;
    pushCnt = 0;
    expQ.delete();
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #3;
    check(pixValid == 1'b0, "R1", 32'(pixValid), 32'd0);
    check(inReady == 1'b1, "R1", 32'(inReady), 32'd1);

    for (int i = 0; i < 256; i++) palWrite(i, 12'((i * 173 + 29) % 4096));

    // R5 R6 R12: exhaustive 8-bit indices, no stall, back-to-back
    setup(3, 0, 256, "R5 R6");
    gapCheck = 1;
    havePrev = 0;
    sendLine(3, 0, 256, 0);
    drain();
    gapCheck = 0;

    // R3 R10: 2 bpp near-exhaustive bytes under backpressure
    stallOn = 1;
    setup(1, 0, 1020, "R3 R10");
    sendLine(1, 0, 1020, 0);
    drain();

    // R9: 2 bpp line of 7, leftover dropped, two lines
    setup(1, 0, 7, "R9 R3");
    sendLine(1, 0, 7, 5);
    sendLine(1, 0, 7, 6);
    drain();

    // R4: 4 bpp exhaustive bytes
    setup(2, 0, 512, "R4 R10");
    sendLine(2, 0, 512, 0);
    drain();

    // R9: 4 bpp odd width
    setup(2, 0, 5, "R9 R4");
    sendLine(2, 0, 5, 9);
    sendLine(2, 0, 5, 10);
    drain();

    // R7: 4:4:4 direct, upper bits varied
    stallOn = 0;
    setup(4, 0, 300, "R7");
    gapCheck = 1;
    havePrev = 0;
    sendLine(4, 0, 300, 3);
    drain();
    gapCheck = 0;

    // R8: 5:6:5 direct, with stall
    stallOn = 1;
    setup(7, 1, 300, "R8 R10");
    sendLine(7, 1, 300, 11);
    drain();
    setup(5, 1, 256, "R8");
    sendLine(5, 1, 256, 0);
    drain();
    stallOn = 0;

    // R11: palette rewrite affects later pixels
    setup(3, 0, 3, "R11");
    sendLine(3, 0, 3, 1);
    drain();
    palWrite(8'h55, 12'hA3C);
    sendLine(3, 0, 3, 1);
    drain();

    // R2: mode 0 blocks input and produces nothing
    @(negedge clk);
    modeCode = 3'd0;
    curReq = "R2";
    inValid = 1'b1;
    inData = 16'h00FF;
    for (int i = 0; i < 12; i++) begin
      #3;
      check(inReady == 1'b0, "R2", 32'(inReady), 32'd0);
      check(pixValid == 1'b0, "R2", 32'(pixValid), 32'd0);
      @(negedge clk);
    end
    inValid = 1'b0;
    repeat (4) @(negedge clk);
    check(gotCnt == 0, "R2", 32'(gotCnt), 32'd0);

    finish();
  end
endmodule